// File: doc/BRIEF.md
# Audible-Band Switching-Period Guard

This block watches the gate-drive signal of a variable-frequency power converter and measures each switching period as a count of system clocks between consecutive rising edges. The gate-drive input is first resynchronised and edge-detected. The count from each completed period is then compared against two independent hysteretic thresholds.

The high detector flags a switching frequency that has fallen close to the top of the audible band. The low detector flags a very light load, where the frequency has already dropped well inside that band. The block combines the two flags into a single peak-current select. The select asks for the reduced peak current only while the high flag is set and the low flag is clear. A reduced peak makes the control loop raise the switching frequency, which keeps the magnetics quiet. At very light load the nominal peak is restored, so the converter can slow down further.

All decisions are taken on gate-drive edges. A result measured in one switching cycle therefore governs the cycles that follow it.

Top module: `audible_band_guard`

## Requirements
- R1: A detector flag is set when a measured period is greater than or equal to that detector's active threshold, and cleared when the period is smaller. A period one clock below the threshold leaves the flag clear.
- R2: The flags change only on a detected rising gate-drive edge, and they hold their value for the whole of every period in between.
- R3: Reset clears both flags and drives `peak_reduce_o` to 0. The first rising edge after reset only starts a measurement and never changes a flag.
- R4: `peak_reduce_o` is 1 (reduced peak) exactly when `hi_flag_o` is 1 and `lo_flag_o` is 0. Otherwise it is 0 (nominal peak).
- R5: While `hi_flag_o` is 0 the high detector compares against `thr_hi_enter`. While it is 1 the detector compares against `thr_hi_exit`, so any period at or above the exit value keeps it set.
- R6: While `lo_flag_o` is 0 the low detector compares against `thr_lo_enter`. While it is 1 the detector compares against `thr_lo_exit`, so any period at or above the exit value keeps it set.
- R7: The measured period is the number of clock cycles between two consecutive rising edges of `gate_i`, each seen through a two-flop synchroniser. Rising edges of `gate_i` spaced P clocks apart measure exactly P.
- R8: The period count saturates at 2^CNT_W-1 and does not wrap. A stalled gate drive therefore reads as the longest possible period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_i | input | 1 | Gate-drive signal, asynchronous to clk |
| thr_hi_enter | input | CNT_W | High detector threshold used while its flag is clear |
| thr_hi_exit | input | CNT_W | High detector threshold used while its flag is set |
| thr_lo_enter | input | CNT_W | Low detector threshold used while its flag is clear |
| thr_lo_exit | input | CNT_W | Low detector threshold used while its flag is set |
| peak_reduce_o | output | 1 | 1 = reduced peak current, 0 = nominal peak |
| hi_flag_o | output | 1 | High detector state |
| lo_flag_o | output | 1 | Low detector state |

## Verification
The bench drives periods one clock below and exactly at the high entry threshold. A design that uses a strict comparison, or that miscounts the period by one clock, sets the flag on the wrong side of that boundary. Periods that fall between the exit and entry values of each detector show whether the hysteresis holds: without it, the flag drops back. A gate stall longer than the counter range checks saturation, because a wrapped count would read as a short period and leave the low flag clear. Sampling mid-stall shows that the flags wait for an edge. The first edge after reset is checked as well: a design that evaluates it would set flags from the time elapsed since reset.

// File: rtl/abg_pkg.sv
package abg_pkg;
   typedef enum logic {
      PEAK_NOMINAL = 1'b0,
      PEAK_REDUCED = 1'b1
   } peak_sel_e;

   typedef enum int {
      DET_HI = 0,
      DET_LO = 1
   } det_idx_e;

   localparam int NUM_DET = 2;
endpackage

// File: rtl/abg_edge_sync.sv
module abg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("abg_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], din};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~prev_q;

   // R7: a detected rise is a single-cycle pulse
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/abg_period_cnt.sv
module abg_period_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= CNT_ONE;
      else if (cnt_q != CNT_MAX)
         cnt_q <= cnt_q + CNT_ONE;
   end

   assign count_o = cnt_q;

   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == CNT_MAX && !restart) |=> count_o == CNT_MAX);

   a_r7_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> count_o == CNT_ONE);
endmodule

// File: rtl/abg_hyst_det.sv
module abg_hyst_det #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] thr_enter,
   input  logic [CNT_W-1:0] thr_exit,
   output logic             flag_o
);
   logic             flag_q;
   logic [CNT_W-1:0] thr_active;

   always_comb thr_active = flag_q ? thr_exit : thr_enter;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (sample)
         flag_q <= (period >= thr_active);
   end

   assign flag_o = flag_q;

   a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
      !sample |=> $stable(flag_o));

   a_r1_enter_at_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && !flag_o && period >= thr_enter) |=> flag_o);

   a_r5_hold_above_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && flag_o && period >= thr_exit) |=> flag_o);

   a_r1_clear_below_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && flag_o && period < thr_exit) |=> !flag_o);
endmodule

// File: rtl/audible_band_guard.sv
module audible_band_guard #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_i,
   input  logic [CNT_W-1:0] thr_hi_enter,
   input  logic [CNT_W-1:0] thr_hi_exit,
   input  logic [CNT_W-1:0] thr_lo_enter,
   input  logic [CNT_W-1:0] thr_lo_exit,
   output logic             peak_reduce_o,
   output logic             hi_flag_o,
   output logic             lo_flag_o
);
   import abg_pkg::*;

   generate
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_width
         $error("audible_band_guard: CNT_W out of range");
      end
   endgenerate

   logic             rise;
   logic             armed_q;
   logic             sample;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] thr_enter_a [NUM_DET];
   logic [CNT_W-1:0] thr_exit_a  [NUM_DET];
   logic             flag_a      [NUM_DET];
   peak_sel_e        peak_sel;

   abg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (gate_i),
      .rise_o (rise)
   );

   abg_period_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (rise),
      .count_o (period)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed_q <= 1'b0;
      else if (rise)
         armed_q <= 1'b1;
   end

   assign sample = rise & armed_q;

   always_comb begin
      thr_enter_a[DET_HI] = thr_hi_enter;
      thr_exit_a [DET_HI] = thr_hi_exit;
      thr_enter_a[DET_LO] = thr_lo_enter;
      thr_exit_a [DET_LO] = thr_lo_exit;
   end

   for (genvar d = 0; d < NUM_DET; d++) begin : g_det
      abg_hyst_det #(.CNT_W(CNT_W)) u_det (
         .clk       (clk),
         .rst_n     (rst_n),
         .sample    (sample),
         .period    (period),
         .thr_enter (thr_enter_a[d]),
         .thr_exit  (thr_exit_a[d]),
         .flag_o    (flag_a[d])
      );
   end

   always_comb
      peak_sel = (flag_a[DET_HI] && !flag_a[DET_LO]) ? PEAK_REDUCED : PEAK_NOMINAL;

   assign peak_reduce_o = peak_sel;
   assign hi_flag_o     = flag_a[DET_HI];
   assign lo_flag_o     = flag_a[DET_LO];

   a_r4_light_load_nominal: assert property (@(posedge clk) disable iff (!rst_n)
      lo_flag_o |-> !peak_reduce_o);

   a_r4_reduce_needs_hi: assert property (@(posedge clk) disable iff (!rst_n)
      peak_reduce_o |-> hi_flag_o);

   a_r3_first_edge_only_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !armed_q) |=> (!hi_flag_o && !lo_flag_o));
endmodule

// File: tb/audible_band_guard_bench.sv
module audible_band_guard_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam int CMAX       = (1 << W) - 1;
   localparam int HI_EN = 200, HI_EX = 150, LO_EN = 800, LO_EX = 600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gate = 1'b0;
   logic peak, hif, lof;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   audible_band_guard u_audible_band_guard (
      .clk          (clk),
      .rst_n        (rst_n),
      .gate_i       (gate),
      .thr_hi_enter (16'(HI_EN)),
      .thr_hi_exit  (16'(HI_EX)),
      .thr_lo_enter (16'(LO_EN)),
      .thr_lo_exit  (16'(LO_EX)),
      .peak_reduce_o(peak),
      .hi_flag_o    (hif),
      .lo_flag_o    (lof)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model: gate history queue, integer period, two hysteretic flags
   bit hist[$];
   int m_cnt = 0;
   bit m_armed = 0, m_hi = 0, m_lo = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{0, 0, 0};
         m_cnt = 0; m_armed = 0; m_hi = 0; m_lo = 0;
      end else begin
         bit edge_now;
         edge_now = hist[1] && !hist[2];
         if (edge_now) begin
            if (m_armed) begin
               m_hi = (m_cnt >= (m_hi ? HI_EX : HI_EN));
               m_lo = (m_cnt >= (m_lo ? LO_EX : LO_EN));
            end
            m_armed = 1;
            m_cnt = 1;
         end else if (m_cnt < CMAX) begin
            m_cnt = m_cnt + 1;
         end
         hist.push_front(gate);
         void'(hist.pop_back());
      end
   end

   task automatic chk(string req, bit act, bit exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R4", peak, m_hi && !m_lo, "peak_reduce_o vs model");
         chk("R5", hif, m_hi, "hi_flag_o vs model");
         chk("R6", lof, m_lo, "lo_flag_o vs model");
      end
   end

   task automatic pulse(int p);
      gate = 1'b1;
      repeat (p/2) @(negedge clk);
      gate = 1'b0;
      repeat (p - p/2) @(negedge clk);
   endtask

   task automatic group(int p, int n);
      for (int i = 0; i < n; i++) pulse(p);
   endtask

   task automatic expect3(string req, bit e_peak, bit e_hi, bit e_lo);
      chk(req, peak, e_peak, "peak_reduce_o");
      chk(req, hif, e_hi, "hi_flag_o");
      chk(req, lof, e_lo, "lo_flag_o");
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<190000 cycles", cycles);
         finish_run();
      end
   end

   initial begin
      #1;
      expect3("R3", 0, 0, 0);           // R3: reset state
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (300) @(negedge clk);      // long gap before first edge
      pulse(100);
      expect3("R3", 0, 0, 0);           // R3: first edge only arms
      group(100, 3);
      expect3("R1", 0, 0, 0);
      group(199, 2);
      expect3("R1", 0, 0, 0);           // R1/R7: one below entry stays clear
      group(200, 2);
      expect3("R1", 1, 1, 0);           // R1/R7: equal to entry sets
      group(170, 2);
      expect3("R5", 1, 1, 0);           // R5: above exit keeps high flag
      group(140, 2);
      expect3("R5", 0, 0, 0);           // R5: below exit clears
      group(220, 2);
      expect3("R4", 1, 1, 0);
      group(900, 2);
      expect3("R6", 0, 1, 1);           // R6/R4: light load restores nominal
      group(700, 2);
      expect3("R6", 0, 1, 1);           // R6: between exit and entry holds
      group(500, 2);
      expect3("R6", 1, 1, 0);           // R6: below exit clears
      group(100, 2);
      expect3("R4", 0, 0, 0);
      // R2: stall longer than counter range; flags wait for an edge
      gate = 1'b1;
      repeat (50) @(negedge clk);
      gate = 1'b0;
      repeat (3000) @(negedge clk);
      expect3("R2", 0, 0, 0);           // R2: no change mid-period
      repeat (66000 - 3050) @(negedge clk);
      pulse(100);
      expect3("R8", 0, 1, 1);           // R8: saturated count, no wrap
      group(100, 2);
      expect3("R8", 0, 0, 0);
      finish_run();
   end
endmodule